// File: doc/BRIEF.md
# Piecewise-Linear Thermal Code Converter

This block turns a raw thermal-sensor reading into a signed temperature in millidegrees Celsius. A calibration table of (code, temperature) points, 5 °C apart from -40 °C to +125 °C, is built at elaboration from parameters. A conversion masks the reading to the active data width and checks it against the table's end entries. It then runs a binary search, one probe per cycle, for the segment whose two end codes enclose the reading. Inside that segment it interpolates linearly, using a restoring divider that produces one quotient bit per cycle.

The same table serves sensors whose code rises with temperature and sensors whose code falls with temperature. A direction input selects which one applies. The block also runs the lookup in reverse, from a threshold temperature to a table code, which a trip comparator can use. Each request starts on a one-cycle strobe. Completion is a one-cycle done pulse, and the result registers hold their value until a later request overwrites them.

Top module: `pwl_temp_conv`

## Requirements
- R1: While reset is asserted, and after it is released until the first request completes, `done`, `invalid`, `temp_out` and `code_out` are all zero.
- R2: Only the low 10 bits (DATA_W) of `code_in` take part in a conversion. Bits 11:10 have no effect on the result.
- R3: Rising table (`desc`=0): the code at entry i is 200+16i+floor(i²/4), for i = 0..33, and the temperature at entry i is -40000+5000i millidegrees. A reading c with code[m-1] ≤ c < code[m] gives temp[m-1] + floor(5000·(c-code[m-1]) / (code[m]-code[m-1])).
- R4: Falling table (`desc`=1): the code at entry i is 1020-(200+16i+floor(i²/4)). A reading c with code[m] ≤ c < code[m-1] gives temp[m-1] + floor(5000·(code[m-1]-c) / (code[m-1]-code[m])).
- R5: A reading equal to a table code converts to that entry's temperature exactly, whenever the bracketing rule of R3 or R4 covers it. This includes the last falling entry, which gives 125000.
- R6: A reading below the first rising code, or below the last falling code, is rejected with `invalid`=1. The rejection comes without a search.
- R7: A reading that no segment brackets is rejected with `invalid`=1. Examples are a rising reading at or above the last code, or a falling reading at or above the first code. On any rejection, `temp_out` and `code_out` keep their earlier values.
- R8: With `op_rev`=1, a `temp_in` equal to a table temperature returns that entry's code for the selected direction on `code_out`. `temp_out` is left unchanged.
- R9: With `op_rev`=1, a `temp_in` outside -40000..125000, or one that falls between two entries, is rejected with `invalid`=1. `code_out` is left unchanged.
- R10: `done` is high for exactly one cycle per accepted request. Outputs change only in a `done` cycle. A `start` given in the `done` cycle is accepted as a new request.
- R11: A `start` that arrives while a request is in progress is ignored. It produces no `done` and does not disturb the running request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request strobe |
| op_rev | input | 1 | 0: code to temperature, 1: temperature to code |
| desc | input | 1 | 0: codes rise with temperature, 1: codes fall with temperature |
| code_in | input | 12 | Raw sensor reading |
| temp_in | input | 32 | Signed threshold temperature in millidegrees, used for reverse lookups |
| done | output | 1 | One-cycle completion pulse |
| invalid | output | 1 | Last request was rejected |
| temp_out | output | 32 | Signed converted temperature in millidegrees |
| code_out | output | 10 | Code returned by a reverse lookup |

## Verification
Two things can happen in the same cycle: delivery of one result and acceptance of the next start, because the `done` cycle already finds the controller idle. The bench drives a fresh start in exactly the cycle where it sees `done` high. The scoreboard then expects both results in order, with no extra and no missing pulse. The opposite case is a start given in the middle of a search. That start must produce no result at all, which is judged by matching the count of done pulses against the count of accepted requests after the block has settled.

// File: rtl/pwl_temp_pkg.sv
package pwl_temp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_DIV    = 2'd2
  } pwl_state_e;

  // Calibration code for table slot idx; the falling table mirrors the rising one.
  function automatic int entry_code(int idx, int base, int slope, int top, bit fall);
    int rise;
    rise = base + slope * idx + (idx * idx) / 4;
    return fall ? (top - rise) : rise;
  endfunction

  // Calibration temperature (millidegrees) for table slot idx.
  function automatic int entry_temp(int idx, int lo, int step);
    return lo + step * idx;
  endfunction

endpackage

// File: rtl/pwl_temp_rom.sv
module pwl_temp_rom
  import pwl_temp_pkg::*;
#(
  parameter int N_ENT      = 34,
  parameter int IW         = 6,
  parameter int DATA_W     = 10,
  parameter int TEMP_W     = 32,
  parameter int TEMP_LO    = -40000,
  parameter int TEMP_STEP  = 5000,
  parameter int CODE_BASE  = 200,
  parameter int CODE_SLOPE = 16,
  parameter int CODE_TOP   = 1020
) (
  input  logic                     desc,
  input  logic [IW-1:0]            idx,
  output logic [DATA_W-1:0]        code_cur,
  output logic [DATA_W-1:0]        code_prev,
  output logic signed [TEMP_W-1:0] temp_cur,
  output logic signed [TEMP_W-1:0] temp_prev
);

  logic [DATA_W-1:0]        up_tab [N_ENT];
  logic [DATA_W-1:0]        dn_tab [N_ENT];
  logic signed [TEMP_W-1:0] t_tab  [N_ENT];

  generate
    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
      assign up_tab[g] = DATA_W'(entry_code(g, CODE_BASE, CODE_SLOPE, CODE_TOP, 1'b0));
      assign dn_tab[g] = DATA_W'(entry_code(g, CODE_BASE, CODE_SLOPE, CODE_TOP, 1'b1));
      assign t_tab[g]  = TEMP_W'(entry_temp(g, TEMP_LO, TEMP_STEP));
    end
  endgenerate

  logic [IW-1:0] pidx;
  assign pidx = (idx == '0) ? '0 : idx - IW'(1);

  assign code_cur  = desc ? dn_tab[idx]  : up_tab[idx];
  assign code_prev = desc ? dn_tab[pidx] : up_tab[pidx];
  assign temp_cur  = t_tab[idx];
  assign temp_prev = t_tab[pidx];

endmodule

// File: rtl/pwl_temp_div.sv
module pwl_temp_div #(
  parameter int NW = 23,
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [NW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic [NW-1:0] quotient,
  output logic          fin
);

  localparam int CW = $clog2(NW + 1);

  logic          act_q, act_n;
  logic          fin_q, fin_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [NW-1:0] dvd_q, dvd_n;
  logic [DW-1:0] dsr_q, dsr_n;
  logic [DW-1:0] rem_q, rem_n;
  logic [NW-1:0] quo_q, quo_n;

  logic [DW:0]   trial;
  logic          fits;
  logic [DW-1:0] rem_step;

  // One restoring step: shift next dividend bit into the partial remainder.
  always_comb begin
    trial    = {rem_q, dvd_q[NW-1]};
    fits     = trial >= {1'b0, dsr_q};
    rem_step = fits ? DW'(trial - {1'b0, dsr_q}) : trial[DW-1:0];
  end

  always_comb begin
    act_n = act_q;
    fin_n = 1'b0;
    cnt_n = cnt_q;
    dvd_n = dvd_q;
    dsr_n = dsr_q;
    rem_n = rem_q;
    quo_n = quo_q;
    if (go) begin
      act_n = 1'b1;
      cnt_n = CW'(NW);
      dvd_n = dividend;
      dsr_n = divisor;
      rem_n = '0;
      quo_n = '0;
    end else if (act_q) begin
      dvd_n = {dvd_q[NW-2:0], 1'b0};
      quo_n = {quo_q[NW-2:0], fits};
      rem_n = rem_step;
      cnt_n = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        act_n = 1'b0;
        fin_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      fin_q <= 1'b0;
      cnt_q <= '0;
      dvd_q <= '0;
      dsr_q <= '0;
      rem_q <= '0;
      quo_q <= '0;
    end else begin
      act_q <= act_n;
      fin_q <= fin_n;
      cnt_q <= cnt_n;
      dvd_q <= dvd_n;
      dsr_q <= dsr_n;
      rem_q <= rem_n;
      quo_q <= quo_n;
    end
  end

  assign quotient = quo_q;
  assign fin      = fin_q;

endmodule

// File: rtl/pwl_temp_conv.sv
module pwl_temp_conv
  import pwl_temp_pkg::*;
#(
  parameter int CODE_W     = 12,
  parameter int DATA_W     = 10,
  parameter int TEMP_W     = 32,
  parameter int N_ENT      = 34,
  parameter int TEMP_LO    = -40000,
  parameter int TEMP_STEP  = 5000,
  parameter int CODE_BASE  = 200,
  parameter int CODE_SLOPE = 16,
  parameter int CODE_TOP   = 1020
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     op_rev,
  input  logic                     desc,
  input  logic [CODE_W-1:0]        code_in,
  input  logic signed [TEMP_W-1:0] temp_in,
  output logic                     done,
  output logic                     invalid,
  output logic signed [TEMP_W-1:0] temp_out,
  output logic [DATA_W-1:0]        code_out
);

  localparam int IW      = $clog2(N_ENT);
  localparam int SW      = IW + 2;
  localparam int STEP_W  = $clog2(TEMP_STEP + 1);
  localparam int NUM_W   = STEP_W + DATA_W;
  localparam int TEMP_HI = TEMP_LO + TEMP_STEP * (N_ENT - 1);

  localparam logic [DATA_W-1:0] UP_FIRST =
    DATA_W'(entry_code(0, CODE_BASE, CODE_SLOPE, CODE_TOP, 1'b0));
  localparam logic [DATA_W-1:0] DN_LAST =
    DATA_W'(entry_code(N_ENT - 1, CODE_BASE, CODE_SLOPE, CODE_TOP, 1'b1));
  localparam logic signed [TEMP_W-1:0] T_LO = TEMP_W'(TEMP_LO);
  localparam logic signed [TEMP_W-1:0] T_HI = TEMP_W'(TEMP_HI);
  localparam logic signed [SW-1:0]     IDX_ONE  = SW'(1);
  localparam logic signed [SW-1:0]     IDX_LAST = SW'(N_ENT - 1);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  // State
  pwl_state_e               state_q, state_n;
  logic                     op_q, op_n;
  logic                     desc_q, desc_n;
  logic [DATA_W-1:0]        code_q, code_n;
  logic signed [TEMP_W-1:0] treq_q, treq_n;
  logic signed [SW-1:0]     low_q, low_n;
  logic signed [SW-1:0]     high_q, high_n;
  logic signed [TEMP_W-1:0] base_q, base_n;
  logic [NUM_W-1:0]         num_q, num_n;
  logic [DATA_W-1:0]        den_q, den_n;
  logic                     go_q, go_n;
  logic                     done_q, done_n;
  logic                     inv_q, inv_n;
  logic signed [TEMP_W-1:0] tout_q, tout_n;
  logic [DATA_W-1:0]        cout_q, cout_n;

  logic                     busy;
  logic [DATA_W-1:0]        code_m;
  logic                     unused_hi_bits;

  assign busy           = (state_q != ST_IDLE);
  assign code_m         = code_in[DATA_W-1:0];
  assign unused_hi_bits = ^code_in[CODE_W-1:DATA_W];

  // Search probe
  logic signed [SW-1:0]     mid_s;
  logic [DATA_W-1:0]        code_cur, code_prev;
  logic signed [TEMP_W-1:0] temp_cur, temp_prev;

  assign mid_s = (low_q + high_q) >>> 1;

  pwl_temp_rom #(
    .N_ENT(N_ENT), .IW(IW), .DATA_W(DATA_W), .TEMP_W(TEMP_W),
    .TEMP_LO(TEMP_LO), .TEMP_STEP(TEMP_STEP),
    .CODE_BASE(CODE_BASE), .CODE_SLOPE(CODE_SLOPE), .CODE_TOP(CODE_TOP)
  ) u_rom (
    .desc     (desc_q),
    .idx      (mid_s[IW-1:0]),
    .code_cur (code_cur),
    .code_prev(code_prev),
    .temp_cur (temp_cur),
    .temp_prev(temp_prev)
  );

  // Segment test and interpolation operands for the probed entry
  logic                     hit, go_up;
  logic [DATA_W-1:0]        delta, span;
  logic signed [TEMP_W-1:0] tstep;
  logic [NUM_W-1:0]         num_w;

  always_comb begin
    if (desc_q) begin
      hit   = (code_q >= code_cur) && (code_q < code_prev);
      go_up = (code_q < code_cur);
      delta = code_prev - code_q;
      span  = code_prev - code_cur;
    end else begin
      hit   = (code_q >= code_prev) && (code_q < code_cur);
      go_up = (code_q >= code_cur);
      delta = code_q - code_prev;
      span  = code_cur - code_prev;
    end
    tstep = temp_cur - temp_prev;
    num_w = NUM_W'(tstep) * NUM_W'(delta);
  end

  // Divider
  logic [NUM_W-1:0] quot;
  logic             div_fin;

  pwl_temp_div #(.NW(NUM_W), .DW(DATA_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_i),
    .go      (go_q),
    .dividend(num_q),
    .divisor (den_q),
    .quotient(quot),
    .fin     (div_fin)
  );

  // Next-state logic
  logic reject;

  always_comb begin
    state_n = state_q;
    op_n    = op_q;
    desc_n  = desc_q;
    code_n  = code_q;
    treq_n  = treq_q;
    low_n   = low_q;
    high_n  = high_q;
    base_n  = base_q;
    num_n   = num_q;
    den_n   = den_q;
    go_n    = 1'b0;
    done_n  = 1'b0;
    inv_n   = inv_q;
    tout_n  = tout_q;
    cout_n  = cout_q;
    reject  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          op_n   = op_rev;
          desc_n = desc;
          code_n = code_m;
          treq_n = temp_in;
          high_n = IDX_LAST;
          if (op_rev) begin
            low_n  = '0;
            reject = (temp_in < T_LO) || (temp_in > T_HI);
          end else begin
            low_n  = IDX_ONE;
            reject = desc ? (code_m < DN_LAST) : (code_m < UP_FIRST);
          end
          if (reject) begin
            done_n = 1'b1;
            inv_n  = 1'b1;
          end else begin
            state_n = ST_SEARCH;
          end
        end
      end
      ST_SEARCH: begin
        if (low_q > high_q) begin
          done_n  = 1'b1;
          inv_n   = 1'b1;
          state_n = ST_IDLE;
        end else if (op_q) begin
          if (treq_q == temp_cur) begin
            cout_n  = code_cur;
            inv_n   = 1'b0;
            done_n  = 1'b1;
            state_n = ST_IDLE;
          end else if (treq_q < temp_cur) begin
            high_n = mid_s - IDX_ONE;
          end else begin
            low_n = mid_s + IDX_ONE;
          end
        end else begin
          if (hit) begin
            base_n  = temp_prev;
            num_n   = num_w;
            den_n   = span;
            go_n    = 1'b1;
            state_n = ST_DIV;
          end else if (go_up) begin
            low_n = mid_s + IDX_ONE;
          end else begin
            high_n = mid_s - IDX_ONE;
          end
        end
      end
      ST_DIV: begin
        if (div_fin) begin
          tout_n  = base_q + $signed({{(TEMP_W - NUM_W){1'b0}}, quot});
          inv_n   = 1'b0;
          done_n  = 1'b1;
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_IDLE;
      op_q    <= 1'b0;
      desc_q  <= 1'b0;
      code_q  <= '0;
      treq_q  <= '0;
      low_q   <= '0;
      high_q  <= '0;
      base_q  <= '0;
      num_q   <= '0;
      den_q   <= '0;
      go_q    <= 1'b0;
      done_q  <= 1'b0;
      inv_q   <= 1'b0;
      tout_q  <= '0;
      cout_q  <= '0;
    end else begin
      state_q <= state_n;
      op_q    <= op_n;
      desc_q  <= desc_n;
      code_q  <= code_n;
      treq_q  <= treq_n;
      low_q   <= low_n;
      high_q  <= high_n;
      base_q  <= base_n;
      num_q   <= num_n;
      den_q   <= den_n;
      go_q    <= go_n;
      done_q  <= done_n;
      inv_q   <= inv_n;
      tout_q  <= tout_n;
      cout_q  <= cout_n;
    end
  end

  assign done     = done_q;
  assign invalid  = inv_q;
  assign temp_out = tout_q;
  assign code_out = cout_q;

endmodule

// File: rtl/pwl_temp_conv_chk.sv
module pwl_temp_conv_chk #(
  parameter int TEMP_W  = 32,
  parameter int DATA_W  = 10,
  parameter int TEMP_LO = -40000,
  parameter int TEMP_HI = 125000
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start,
  input logic                     done,
  input logic                     invalid,
  input logic signed [TEMP_W-1:0] temp_out,
  input logic [DATA_W-1:0]        code_out,
  input logic                     busy,
  input logic                     op_q
);

  localparam logic signed [TEMP_W-1:0] T_LO = TEMP_W'(TEMP_LO);
  localparam logic signed [TEMP_W-1:0] T_HI = TEMP_W'(TEMP_HI);

  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: result registers move only in a done cycle
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(temp_out) && $stable(code_out) && $stable(invalid)));

  // R7: a rejection leaves both results untouched
  p_inval_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && invalid) |-> ($stable(temp_out) && $stable(code_out)));

  // R3: an accepted conversion lands inside the table span
  p_temp_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !invalid && !op_q) |-> ((temp_out >= T_LO) && (temp_out <= T_HI)));

  // R8: a reverse lookup never alters the temperature result
  p_rev_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q) |-> $stable(temp_out));

  // R11: a start during a running request does not reload it
  p_ignore_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(op_q));

endmodule

bind pwl_temp_conv pwl_temp_conv_chk #(
  .TEMP_W (TEMP_W),
  .DATA_W (DATA_W),
  .TEMP_LO(TEMP_LO),
  .TEMP_HI(TEMP_HI)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .done    (done),
  .invalid (invalid),
  .temp_out(temp_out),
  .code_out(code_out),
  .busy    (busy),
  .op_q    (op_q)
);

// File: tb/pwl_temp_conv_test.sv
module pwl_temp_conv_test;

  localparam int CLK_PERIOD = 10;
  localparam int N_ENT      = 34;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               start;
  logic               op_rev;
  logic               desc;
  logic [11:0]        code_in;
  logic signed [31:0] temp_in;
  logic               done;
  logic               invalid;
  logic signed [31:0] temp_out;
  logic [9:0]         code_out;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwl_temp_conv uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_rev(op_rev), .desc(desc),
    .code_in(code_in), .temp_in(temp_in), .done(done), .invalid(invalid),
    .temp_out(temp_out), .code_out(code_out)
  );

  typedef struct {
    logic               inv;
    logic signed [31:0] t;
    logic [9:0]         c;
    string              tag;
  } exp_s;

  exp_s q[$];
  int   checks = 0;
  int   errors = 0;
  int   pushes = 0;
  int   dones  = 0;
  int   last_t = 0;
  int   last_c = 0;
  bit   prev_done = 1'b0;

  // Calibration model taken from the requirements
  function automatic int rc(int i);
    return 200 + 16 * i + (i * i) / 4;
  endfunction
  function automatic int tcode(int i, bit d);
    return d ? 1020 - rc(i) : rc(i);
  endfunction
  function automatic int ttemp(int i);
    return -40000 + 5000 * i;
  endfunction

  function automatic exp_s predict(bit rev, bit d, logic [11:0] code, int tin, string tag);
    exp_s e;
    bit   ok;
    int   c, ca, cb, dl, sp;
    ok = 1'b0;
    if (!rev) begin
      c = int'(code[9:0]);
      for (int m = 1; m < N_ENT; m++) begin
        ca = tcode(m, d);
        cb = tcode(m - 1, d);
        if (!ok && (d ? (c >= ca && c < cb) : (c >= cb && c < ca))) begin
          ok = 1'b1;
          dl = d ? cb - c : c - cb;
          sp = d ? cb - ca : ca - cb;
          last_t = ttemp(m - 1) + (5000 * dl) / sp;
        end
      end
    end else begin
      for (int i = 0; i < N_ENT; i++) begin
        if (!ok && ttemp(i) == tin) begin
          ok = 1'b1;
          last_c = tcode(i, d);
        end
      end
    end
    e.inv = !ok;
    e.t   = last_t;
    e.c   = 10'(last_c);
    e.tag = tag;
    return e;
  endfunction

  task automatic chk(bit ok, string msg, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", msg, act, expv);
    end
  endtask

  task automatic issue(bit rev, bit d, logic [11:0] code, int tin, string tag);
    q.push_back(predict(rev, d, code, tin, tag));
    pushes++;
    @(negedge clk);
    start   = 1'b1;
    op_rev  = rev;
    desc    = d;
    code_in = code;
    temp_in = tin;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic run(bit rev, bit d, logic [11:0] code, int tin, string tag);
    issue(rev, d, code, tin, tag);
    drain();
  endtask

  // Monitor and scoreboard
  always @(negedge clk) begin
    exp_s e;
    if (rst_n) begin
      if (done) begin
        dones++;
        chk(!prev_done, "R10 done longer than one cycle", 1, 0);
        if (q.size() == 0) begin
          chk(1'b0, "R11 done with no accepted request", 1, 0);
        end else begin
          e = q.pop_front();
          chk(invalid === e.inv, {e.tag, " invalid"}, int'(invalid), int'(e.inv));
          chk(temp_out === e.t, {e.tag, " temp_out"}, temp_out, e.t);
          chk(code_out === e.c, {e.tag, " code_out"}, int'(code_out), int'(e.c));
        end
      end
      prev_done = done;
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: run did not complete act=0 exp=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    start   = 1'b0;
    op_rev  = 1'b0;
    desc    = 1'b0;
    code_in = '0;
    temp_in = '0;
    repeat (4) @(negedge clk);
    chk(done == 1'b0 && invalid == 1'b0, "R1 flags in reset", int'({done, invalid}), 0);
    chk(temp_out == 0 && code_out == 0, "R1 results in reset", temp_out, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(done == 1'b0 && temp_out == 0 && code_out == 0, "R1 after release", temp_out, 0);

    // R3 rising table, R5 exact entries
    run(1'b0, 1'b0, 12'd200, 0, "R5 rising first entry");
    run(1'b0, 1'b0, 12'd210, 0, "R3 rising low segment");
    run(1'b0, 1'b0, 12'd600, 0, "R3 rising mid segment");
    run(1'b0, 1'b0, 12'd999, 0, "R3 rising top segment");
    run(1'b0, 1'b0, 12'(rc(17)), 0, "R5 rising exact inner entry");
    // R4 falling table
    run(1'b0, 1'b1, 12'd20, 0, "R5 falling last entry");
    run(1'b0, 1'b1, 12'd500, 0, "R4 falling mid segment");
    run(1'b0, 1'b1, 12'd819, 0, "R4 falling first segment");
    run(1'b0, 1'b1, 12'(1020 - rc(9)), 0, "R5 falling exact inner entry");
    // R6 early rejection, R7 unbracketed codes
    run(1'b0, 1'b0, 12'd100, 0, "R6 rising below first code");
    run(1'b0, 1'b1, 12'd10, 0, "R6 falling below last code");
    run(1'b0, 1'b0, 12'd1000, 0, "R7 rising at last code");
    run(1'b0, 1'b0, 12'd1023, 0, "R7 rising above table");
    run(1'b0, 1'b1, 12'd820, 0, "R7 falling at first code");
    // R2 upper bits masked
    run(1'b0, 1'b0, 12'hC00 | 12'd300, 0, "R2 rising masked bits");
    run(1'b0, 1'b1, 12'h800 | 12'd500, 0, "R2 falling masked bits");
    // R8 and R9 reverse lookup
    run(1'b1, 1'b0, 12'd0, 25000, "R8 reverse rising");
    run(1'b1, 1'b1, 12'd0, 25000, "R8 reverse falling");
    run(1'b1, 1'b0, 12'd0, -40000, "R8 reverse cold end");
    run(1'b1, 1'b1, 12'd0, 125000, "R8 reverse hot end");
    run(1'b1, 1'b0, 12'd0, 25001, "R9 reverse between entries");
    run(1'b1, 1'b0, 12'd0, 130000, "R9 reverse above span");
    run(1'b1, 1'b1, 12'd0, -45000, "R9 reverse below span");
    // Sweep both directions, R3 and R4
    for (int c = 0; c < 1024; c += 41) begin
      run(1'b0, 1'b0, 12'(c), 0, "R3 rising sweep");
      run(1'b0, 1'b1, 12'(c), 0, "R4 falling sweep");
    end

    // R11 start during a search, R10 start in the done cycle
    issue(1'b0, 1'b0, 12'd650, 0, "R11 running request");
    repeat (3) @(negedge clk);
    start   = 1'b1;
    code_in = 12'd300;
    desc    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    q.push_back(predict(1'b0, 1'b1, 12'd777, 0, "R10 start in done cycle"));
    pushes++;
    start   = 1'b1;
    op_rev  = 1'b0;
    desc    = 1'b1;
    code_in = 12'd777;
    @(negedge clk);
    start = 1'b0;
    drain();
    repeat (60) @(negedge clk);
    chk(dones == pushes, "R11 done count vs accepted requests", dones, pushes);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule